// File: doc/BRIEF.md
# Shared Byte FIFO with Water-Level Alerts

A single byte-wide buffer of 64 entries that two parties share: a host register port and an internal data engine. Either side may push bytes into the buffer or pop bytes out of it, so data pushed by the host can be drained by the engine and the reverse. The block reports the current fill count and raises two alert flags against a programmable water level. The high alert looks at free space and the low alert looks at the fill count. An interrupt unit uses these flags to tell the host when to refill the buffer or when to drain it.

Each alert flag has a one-cycle pulse that marks the cycle in which the flag becomes true, and these pulses feed the interrupt logic. A push into a full buffer is discarded and sets an overflow error flag that stays set. A flush input empties the buffer in one cycle. When both ports access the buffer in the same cycle, the engine goes first and the host access waits in a one-entry holding slot.

Top module: `byte_fifo_wm`

## Requirements
- R1: After reset `fill_len_o` is 0, `empty_o` is 1, `full_o` is 0 and `overflow_o` is 0. `fill_len_o` is a 7-bit count from 0 to 64. `empty_o` is 1 exactly when the count is 0, and `full_o` is 1 exactly when the count is 64.
- R2: Bytes leave the buffer in the order they entered it, whichever port pushed them and whichever port pops them.
- R3: `hi_alert_o` is 1 exactly when 64 minus `fill_len_o` is less than or equal to `water_level_i`.
- R4: `lo_alert_o` is 1 exactly when `fill_len_o` is less than or equal to `water_level_i`.
- R5: `hi_alert_pulse_o` and `lo_alert_pulse_o` are each high for exactly one cycle: the first cycle in which the matching alert flag is 1 after a cycle in which it was 0. No pulse is produced by leaving reset.
- R6: A push applied while the buffer holds 64 bytes is discarded and the stored bytes are unchanged. From the next cycle `overflow_o` is 1, and it stays 1 until a flush.
- R7: A pop applied while the buffer is empty leaves `fill_len_o` at 0, and that port's read-data output keeps its previous value.
- R8: While `flush_i` is 1, any access in that cycle is ignored and any waiting host access is dropped. In the next cycle `fill_len_o` is 0 and `overflow_o` is 0.
- R9: When the engine and the host both access the buffer in the same cycle, the engine access is applied in that cycle. The host access is held and applied in the first later cycle with no engine access.
- R10: If a port asserts push and pop in the same cycle, only the push is applied.
- R11: Each port has its own read-data register. It is loaded with the oldest byte at the end of the cycle in which a pop from that port is applied, and it keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the buffer and clear the overflow flag |
| water_level_i | input | 6 | Programmable water level for both alerts |
| host_push_i | input | 1 | Host push request |
| host_pop_i | input | 1 | Host pop request |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Last byte popped by the host |
| eng_push_i | input | 1 | Engine push request |
| eng_pop_i | input | 1 | Engine pop request |
| eng_wdata_i | input | 8 | Engine write byte |
| eng_rdata_o | output | 8 | Last byte popped by the engine |
| fill_len_o | output | 7 | Number of stored bytes, 0 to 64 |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| hi_alert_o | output | 1 | Free space at or below the water level |
| lo_alert_o | output | 1 | Fill count at or below the water level |
| overflow_o | output | 1 | Sticky error: a push hit a full buffer |
| hi_alert_pulse_o | output | 1 | One-cycle event when the high alert becomes true |
| lo_alert_pulse_o | output | 1 | One-cycle event when the low alert becomes true |

## Verification
The hardest situation to reach is the host holding slot. It fills only when both ports request in the same cycle. It is emptied either by an idle engine cycle or by a flush, and the bench arranges both cases. The second case is a collision followed at once by a flush, and the bench then checks that the waiting byte never shows up in the count. Overflow and both alert edges need the buffer driven to its limits. The bench therefore fills the buffer one byte per cycle with a raised water level, pushes past capacity twice, and drains it again with the engine. Along the way it checks each flag and pulse at every fill level and checks the byte order across the discarded pushes.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;
  // Kind of access presented to the storage in one cycle
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } fifo_op_e;
endpackage

// File: rtl/fifo_wm_arb.sv
// Chooses one access per cycle; engine first, host parked in a one-entry slot.
module fifo_wm_arb
  import fifo_wm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              host_push_i,
  input  logic              host_pop_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              eng_push_i,
  input  logic              eng_pop_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  output fifo_op_e          op_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_host_o
);

  fifo_op_e            host_op, eng_op;
  logic                slot_q, slot_d;
  fifo_op_e            slot_op_q, slot_op_d;
  logic [DATA_W-1:0]   slot_data_q, slot_data_d;

  // push wins over pop within one port
  always_comb begin
    host_op = host_push_i ? OP_PUSH : (host_pop_i ? OP_POP : OP_NONE);
    eng_op  = eng_push_i  ? OP_PUSH : (eng_pop_i  ? OP_POP : OP_NONE);
  end

  always_comb begin
    op_o        = OP_NONE;
    op_data_o   = eng_wdata_i;
    op_host_o   = 1'b0;
    slot_d      = slot_q;
    slot_op_d   = host_op;
    slot_data_d = host_wdata_i;
    if (flush_i) begin
      slot_d = 1'b0;
    end else if (eng_op != OP_NONE) begin
      op_o = eng_op;
      if (!slot_q && host_op != OP_NONE) begin
        slot_d = 1'b1;
      end
    end else if (slot_q) begin
      op_o      = slot_op_q;
      op_data_o = slot_data_q;
      op_host_o = 1'b1;
      slot_d    = (host_op != OP_NONE);
    end else if (host_op != OP_NONE) begin
      op_o      = host_op;
      op_data_o = host_wdata_i;
      op_host_o = 1'b1;
    end
  end

  logic slot_load;
  assign slot_load = slot_d && !(slot_q && eng_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= 1'b0;
    else        slot_q <= slot_d;
  end

  always_ff @(posedge clk) begin
    if (slot_load) begin
      slot_op_q   <= slot_op_d;
      slot_data_q <= slot_data_d;
    end
  end

endmodule

// File: rtl/fifo_wm_store.sv
// Circular byte store with fill count, sticky overflow and per-port read registers.
module fifo_wm_store
  import fifo_wm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  fifo_op_e          op_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              op_host_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [DATA_W-1:0] eng_rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              ovf_q, ovf_d;
  logic              is_full, is_empty, do_wr, do_rd, drop;
  logic [DATA_W-1:0] head;

  always_comb begin
    is_full  = (count_q == CNT_W'(DEPTH));
    is_empty = (count_q == '0);
    do_wr    = (op_i == OP_PUSH) && !is_full  && !flush_i;
    do_rd    = (op_i == OP_POP)  && !is_empty && !flush_i;
    drop     = (op_i == OP_PUSH) &&  is_full  && !flush_i;
    head     = mem_q[rd_ptr_q];
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    ovf_d    = ovf_q | drop;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
      ovf_d    = 1'b0;
    end else if (do_wr) begin
      wr_ptr_d = wr_ptr_q + PTR_W'(1);
      count_d  = count_q + CNT_W'(1);
    end else if (do_rd) begin
      rd_ptr_d = rd_ptr_q + PTR_W'(1);
      count_d  = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_ptr_q] <= op_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata_o <= '0;
      eng_rdata_o  <= '0;
    end else begin
      if (do_rd &&  op_host_i) host_rdata_o <= head;
      if (do_rd && !op_host_i) eng_rdata_o  <= head;
    end
  end

  assign count_o    = count_q;
  assign overflow_o = ovf_q;

endmodule

// File: rtl/fifo_wm_alert.sv
// Status flags, water-level alerts and their rising-edge events.
module fifo_wm_alert #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVL_W = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             empty_o,
  output logic             full_o,
  output logic             hi_o,
  output logic             lo_o,
  output logic             hi_pulse_o,
  output logic             lo_pulse_o
);

  logic [CNT_W-1:0] space, level_ext;
  logic             hi_seen_q, lo_seen_q;

  always_comb begin
    space      = CNT_W'(DEPTH) - count_i;
    level_ext  = CNT_W'(level_i);
    empty_o    = (count_i == '0);
    full_o     = (count_i == CNT_W'(DEPTH));
    hi_o       = (space <= level_ext);
    lo_o       = (count_i <= level_ext);
    hi_pulse_o = hi_o & ~hi_seen_q;
    lo_pulse_o = lo_o & ~lo_seen_q;
  end

  // Reset values match the flags of an empty buffer, so leaving reset is silent.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_seen_q <= 1'b0;
      lo_seen_q <= 1'b1;
    end else begin
      hi_seen_q <= hi_o;
      lo_seen_q <= lo_o;
    end
  end

endmodule

// File: rtl/byte_fifo_wm.sv
module byte_fifo_wm
  import fifo_wm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LVL_W  = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [LVL_W-1:0]  water_level_i,
  input  logic              host_push_i,
  input  logic              host_pop_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              eng_push_i,
  input  logic              eng_pop_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  output logic [DATA_W-1:0] eng_rdata_o,
  output logic [CNT_W-1:0]  fill_len_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              hi_alert_o,
  output logic              lo_alert_o,
  output logic              overflow_o,
  output logic              hi_alert_pulse_o,
  output logic              lo_alert_pulse_o
);

  fifo_op_e          op;
  logic [DATA_W-1:0] op_data;
  logic              op_host;

  fifo_wm_arb #(.DATA_W(DATA_W)) arb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .host_push_i  (host_push_i),
    .host_pop_i   (host_pop_i),
    .host_wdata_i (host_wdata_i),
    .eng_push_i   (eng_push_i),
    .eng_pop_i    (eng_pop_i),
    .eng_wdata_i  (eng_wdata_i),
    .op_o         (op),
    .op_data_o    (op_data),
    .op_host_o    (op_host)
  );

  fifo_wm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .op_i         (op),
    .op_data_i    (op_data),
    .op_host_i    (op_host),
    .count_o      (fill_len_o),
    .overflow_o   (overflow_o),
    .host_rdata_o (host_rdata_o),
    .eng_rdata_o  (eng_rdata_o)
  );

  fifo_wm_alert #(.DEPTH(DEPTH), .LVL_W(LVL_W)) alert_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (fill_len_o),
    .level_i    (water_level_i),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .hi_o       (hi_alert_o),
    .lo_o       (lo_alert_o),
    .hi_pulse_o (hi_alert_pulse_o),
    .lo_pulse_o (lo_alert_pulse_o)
  );

endmodule

// File: rtl/byte_fifo_wm_chk.sv
module byte_fifo_wm_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              eng_push_i,
  input logic              eng_pop_i,
  input logic [DATA_W-1:0] eng_rdata_o,
  input logic [CNT_W-1:0]  fill_len_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              hi_alert_o,
  input logic              lo_alert_o,
  input logic              overflow_o,
  input logic              hi_alert_pulse_o,
  input logic              lo_alert_pulse_o
);

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_len_o <= CNT_W'(DEPTH));

  // R6
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && eng_push_i && !flush_i) |=> (overflow_o && full_o));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !flush_i) |=> overflow_o);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (fill_len_o == '0 && !overflow_o && empty_o));

  // R9
  eng_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_push_i && !full_o && !flush_i) |=> (fill_len_o == $past(fill_len_o) + CNT_W'(1)));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && eng_pop_i && !eng_push_i && !flush_i) |=> ($stable(eng_rdata_o) && empty_o));

  // R5
  hi_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_alert_pulse_o |-> hi_alert_o);

  // R5
  hi_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_alert_pulse_o |=> !hi_alert_pulse_o);

  // R5
  lo_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_alert_pulse_o |-> lo_alert_o);

  // R5
  lo_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_alert_pulse_o |=> !lo_alert_pulse_o);

endmodule

bind byte_fifo_wm byte_fifo_wm_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .flush_i          (flush_i),
  .eng_push_i       (eng_push_i),
  .eng_pop_i        (eng_pop_i),
  .eng_rdata_o      (eng_rdata_o),
  .fill_len_o       (fill_len_o),
  .empty_o          (empty_o),
  .full_o           (full_o),
  .hi_alert_o       (hi_alert_o),
  .lo_alert_o       (lo_alert_o),
  .overflow_o       (overflow_o),
  .hi_alert_pulse_o (hi_alert_pulse_o),
  .lo_alert_pulse_o (lo_alert_pulse_o)
);

// File: tb/byte_fifo_wm_tb_top.sv
module byte_fifo_wm_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush_i = 1'b0;
  logic [5:0] water_level_i = 6'd8;
  logic       host_push_i = 1'b0, host_pop_i = 1'b0;
  logic [7:0] host_wdata_i = 8'h00;
  logic       eng_push_i = 1'b0, eng_pop_i = 1'b0;
  logic [7:0] eng_wdata_i = 8'h00;
  logic [7:0] host_rdata_o, eng_rdata_o;
  logic [6:0] fill_len_o;
  logic       empty_o, full_o, hi_alert_o, lo_alert_o, overflow_o;
  logic       hi_alert_pulse_o, lo_alert_pulse_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  byte_fifo_wm dut_i (
    .clk (clk), .rst_n (rst_n), .flush_i (flush_i), .water_level_i (water_level_i),
    .host_push_i (host_push_i), .host_pop_i (host_pop_i), .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .eng_push_i (eng_push_i), .eng_pop_i (eng_pop_i), .eng_wdata_i (eng_wdata_i),
    .eng_rdata_o (eng_rdata_o),
    .fill_len_o (fill_len_o), .empty_o (empty_o), .full_o (full_o),
    .hi_alert_o (hi_alert_o), .lo_alert_o (lo_alert_o), .overflow_o (overflow_o),
    .hi_alert_pulse_o (hi_alert_pulse_o), .lo_alert_pulse_o (lo_alert_pulse_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle of stimulus, driven at a falling edge; returns at the next falling edge.
  task automatic step(input bit hpu, input bit hpo, input logic [7:0] hd,
                      input bit epu, input bit epo, input logic [7:0] ed, input bit fl);
    host_push_i = hpu; host_pop_i = hpo; host_wdata_i = hd;
    eng_push_i  = epu; eng_pop_i  = epo; eng_wdata_i  = ed;
    flush_i     = fl;
    @(negedge clk);
    host_push_i = 1'b0; host_pop_i = 1'b0;
    eng_push_i  = 1'b0; eng_pop_i  = 1'b0;
    flush_i     = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 fill", int'(fill_len_o), 0);
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 full", int'(full_o), 0);
    chk("R1 overflow", int'(overflow_o), 0);
    chk("R4 lo alert", int'(lo_alert_o), 1);
    chk("R3 hi alert", int'(hi_alert_o), 0);
    chk("R5 no pulse from reset", int'(lo_alert_pulse_o | hi_alert_pulse_o), 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) step(1, 0, 8'h10 + 8'(i), 0, 0, 8'h00, 0);
    chk("R1 fill after host pushes", int'(fill_len_o), 3);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 8'h00, 0, 1, 8'h00, 0);
      chk("R2 engine pops host data", int'(eng_rdata_o), 'h10 + i);
    end
    step(0, 0, 8'h00, 1, 0, 8'hA0, 0);
    step(0, 0, 8'h00, 1, 0, 8'hA1, 0);
    step(1, 0, 8'hB0, 0, 0, 8'h00, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 8'h00, 0, 0, 8'h00, 0);
      chk("R2 host pops in order", int'(host_rdata_o), (i == 2) ? 'hB0 : ('hA0 + i));
    end
    chk("R11 engine read register kept", int'(eng_rdata_o), 'h12);
    chk("R1 empty after drain", int'(empty_o), 1);
  endtask

  task automatic t_same_port();
    step(1, 1, 8'h3C, 0, 0, 8'h00, 0);
    chk("R10 push wins over pop", int'(fill_len_o), 1);
    step(0, 1, 8'h00, 0, 0, 8'h00, 0);
    chk("R10 pushed byte stored", int'(host_rdata_o), 'h3C);
    chk("R10 fill back to zero", int'(fill_len_o), 0);
  endtask

  task automatic t_conflict();
    step(1, 0, 8'h55, 1, 0, 8'h66, 0);
    chk("R9 only engine applied", int'(fill_len_o), 1);
    step(0, 0, 8'h00, 0, 0, 8'h00, 0);
    chk("R9 host applied next cycle", int'(fill_len_o), 2);
    step(0, 0, 8'h00, 0, 1, 8'h00, 0);
    chk("R9 engine byte first", int'(eng_rdata_o), 'h66);
    step(0, 0, 8'h00, 0, 1, 8'h00, 0);
    chk("R9 host byte second", int'(eng_rdata_o), 'h55);
  endtask

  task automatic t_empty_pop();
    step(0, 0, 8'h00, 0, 1, 8'h00, 0);
    chk("R7 fill stays zero", int'(fill_len_o), 0);
    chk("R7 engine data held", int'(eng_rdata_o), 'h55);
    step(0, 1, 8'h00, 0, 0, 8'h00, 0);
    chk("R7 host data held", int'(host_rdata_o), 'h3C);
  endtask

  task automatic t_fill();
    int wl = 20;
    bit ph = 1'b0;
    bit pl = 1'b1;
    water_level_i = 6'(wl);
    @(negedge clk);
    for (int k = 1; k <= 64; k++) begin
      bit eh, el;
      step(1, 0, 8'(k), 0, 0, 8'h00, 0);
      eh = ((64 - k) <= wl);
      el = (k <= wl);
      chk("R1 fill level", int'(fill_len_o), k);
      chk("R3 hi alert", int'(hi_alert_o), int'(eh));
      chk("R4 lo alert", int'(lo_alert_o), int'(el));
      chk("R5 hi pulse", int'(hi_alert_pulse_o), int'(eh && !ph));
      chk("R5 lo pulse", int'(lo_alert_pulse_o), int'(el && !pl));
      ph = eh; pl = el;
    end
    chk("R1 full", int'(full_o), 1);
    chk("R6 no overflow yet", int'(overflow_o), 0);
    step(1, 0, 8'hEE, 0, 0, 8'h00, 0);
    chk("R6 overflow set", int'(overflow_o), 1);
    chk("R6 fill unchanged", int'(fill_len_o), 64);
    step(0, 0, 8'h00, 1, 0, 8'hEF, 0);
    chk("R6 overflow sticky", int'(overflow_o), 1);
    for (int k = 1; k <= 64; k++) begin
      bit eh, el;
      step(0, 0, 8'h00, 0, 1, 8'h00, 0);
      eh = ((64 - (64 - k)) <= wl);
      el = ((64 - k) <= wl);
      chk("R6 contents unchanged", int'(eng_rdata_o), k);
      chk("R3 hi alert drain", int'(hi_alert_o), int'(eh));
      chk("R5 lo pulse drain", int'(lo_alert_pulse_o), int'(el && !pl));
      ph = eh; pl = el;
    end
    chk("R6 overflow kept after drain", int'(overflow_o), 1);
    water_level_i = 6'd8;
    @(negedge clk);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 3; i++) step(1, 0, 8'h70 + 8'(i), 0, 0, 8'h00, 0);
    step(1, 0, 8'h99, 0, 0, 8'h00, 1);
    chk("R8 fill cleared", int'(fill_len_o), 0);
    chk("R8 overflow cleared", int'(overflow_o), 0);
    chk("R8 access during flush ignored", int'(empty_o), 1);
    step(1, 0, 8'h81, 1, 0, 8'h82, 0);
    step(0, 0, 8'h00, 0, 0, 8'h00, 1);
    step(0, 0, 8'h00, 0, 0, 8'h00, 0);
    chk("R8 waiting host access dropped", int'(fill_len_o), 0);
    step(0, 0, 8'h00, 1, 0, 8'hC4, 0);
    step(0, 1, 8'h00, 0, 0, 8'h00, 0);
    chk("R8 fresh data after flush", int'(host_rdata_o), 'hC4);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_same_port();
    t_conflict();
    t_empty_pop();
    t_fill();
    t_flush();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule